// File: doc/BRIEF.md
# Lane-wise multiply-accumulate by element

This block is the integer datapath for one vector instruction. It receives a 32-bit instruction word together with three 128-bit operands that the register file has already read: a vector source, an indexed source and an accumulator taken from the destination register. It decodes the lane width, the vector length, the lane index and the register numbers. It picks one element of the indexed source and applies it to every lane. Each lane of the vector source is multiplied by that element, and the product is added to the matching accumulator lane.

The result is registered on the edge that follows an input strobe. It leaves the block together with the destination register number and a write enable. Encodings the block does not accept raise an undefined flag and suppress the write. The decoded source register numbers are also presented, so that the register file can check which operands it should have supplied.

Top module: `lane_mac_by_elem`

## Requirements
- R1: A word is accepted only if bit 31 is 0, bit 29 is 1, bits 28:24 are 01111, bits 15:12 are 0000 and bit 10 is 0. Any other word sets out_undef, forces out_write low and drives out_result to zero.
- R2: The lane width is set by bits 23:22. The value 01 selects 16-bit lanes and 10 selects 32-bit lanes. The values 00 and 11 set out_undef, hold out_write low and drive out_result to zero.
- R3: When bit 30 is 0, only bits 63:0 carry lanes and bits 127:64 of out_result are zero. When bit 30 is 1, all 128 bits carry lanes.
- R4: With 16-bit lanes, the element index is the 3-bit value {bit 11, bit 21, bit 20}. The element is taken from bits idx*16 upward of the indexed source. out_isrc_reg is {0, bits 19:16}.
- R5: With 32-bit lanes, the element index is the 2-bit value {bit 11, bit 21}. The element is taken from bits idx*32 upward of the indexed source. out_isrc_reg is {bit 20, bits 19:16}.
- R6: Result lane e equals accumulator lane e plus vector lane e times the selected element, computed without sign. The product is truncated to the lane width and the sum wraps modulo 2 to the lane width.
- R7: out_dst carries bits 4:0 of the word and out_vsrc_reg carries bits 9:5.
- R8: The outputs change on the clock edge after in_valid is high. out_valid is high for exactly that one cycle. out_write equals out_valid when out_undef is low.
- R9: While reset is asserted, out_valid, out_write and out_undef are low and out_result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: the word and the operands are valid |
| instr | input | 32 | Instruction word |
| vsrc | input | 128 | Vector source operand |
| isrc | input | 128 | Indexed source operand |
| acc | input | 128 | Accumulator (the current destination contents) |
| out_valid | output | 1 | Registered result is valid |
| out_write | output | 1 | The result should be written to out_dst |
| out_undef | output | 1 | The word is not an accepted encoding |
| out_result | output | 128 | Result vector |
| out_dst | output | 5 | Destination register number |
| out_vsrc_reg | output | 5 | Vector source register number |
| out_isrc_reg | output | 5 | Decoded indexed register number |

## Verification
The assertions check the following on every cycle: the one-cycle strobe-to-valid timing, the undefined flag for bad size or opcode bits, the suppressed write, the zero upper half for 64-bit vectors, the zero top bit of the indexed register number for 16-bit lanes, and the register number pass-through. The arithmetic itself can only be shown by the bench scenarios. These are lane products that wrap, the choice of element for each index value including the upper half of the indexed source, and random operands for both lane widths and both vector lengths compared against a reference model.

// File: rtl/lane_mac_by_elem.sv
module lane_mac_by_elem (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [31:0]  instr,
  input  logic [127:0] vsrc,
  input  logic [127:0] isrc,
  input  logic [127:0] acc,
  output logic         out_valid,
  output logic         out_write,
  output logic         out_undef,
  output logic [127:0] out_result,
  output logic [4:0]   out_dst,
  output logic [4:0]   out_vsrc_reg,
  output logic [4:0]   out_isrc_reg
);
  localparam int VW   = 128;
  localparam int N16  = VW / 16;
  localparam int N32  = VW / 32;
  localparam int HALF = VW / 2;

  logic         wide, hb, lb, mb, is16, is32, opc_ok, bad;
  logic [1:0]   sz;
  logic [6:0]   off16, off32;
  logic [15:0]  sel16;
  logic [31:0]  sel32;
  logic [VW-1:0] r16, r32, full, res;
  logic [4:0]   ireg;
  logic         undef_q;

  assign wide   = instr[30];
  assign sz     = instr[23:22];
  assign lb     = instr[21];
  assign mb     = instr[20];
  assign hb     = instr[11];
  assign is16   = (sz == 2'b01);
  assign is32   = (sz == 2'b10);
  assign opc_ok = !instr[31] && instr[29] && (instr[28:24] == 5'b01111)
                  && (instr[15:12] == 4'b0000) && !instr[10];
  assign bad    = !opc_ok || !(is16 || is32);

  assign off16  = {hb, lb, mb, 4'b0000};
  assign off32  = {hb, lb, 5'b00000};
  assign sel16  = isrc[off16 +: 16];
  assign sel32  = isrc[off32 +: 32];
  assign ireg   = is32 ? {mb, instr[19:16]} : {1'b0, instr[19:16]};

  for (genvar g = 0; g < N16; g++) begin : g_l16
    assign r16[g*16 +: 16] = acc[g*16 +: 16] + vsrc[g*16 +: 16] * sel16;
  end
  for (genvar g = 0; g < N32; g++) begin : g_l32
    assign r32[g*32 +: 32] = acc[g*32 +: 32] + vsrc[g*32 +: 32] * sel32;
  end

  assign full = is32 ? r32 : r16;
  assign res  = bad ? '0 : (wide ? full : {{HALF{1'b0}}, full[HALF-1:0]});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      undef_q      <= 1'b0;
      out_result   <= '0;
      out_dst      <= '0;
      out_vsrc_reg <= '0;
      out_isrc_reg <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        undef_q      <= bad;
        out_result   <= res;
        out_dst      <= instr[4:0];
        out_vsrc_reg <= instr[9:5];
        out_isrc_reg <= ireg;
      end
    end
  end

  assign out_undef = out_valid && undef_q;
  assign out_write = out_valid && !undef_q;
endmodule

module lane_mac_by_elem_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [31:0]  instr,
  input logic         out_valid,
  input logic         out_write,
  input logic         out_undef,
  input logic [127:0] out_result,
  input logic [4:0]   out_dst,
  input logic [4:0]   out_vsrc_reg,
  input logic [4:0]   out_isrc_reg
);
  a_r8_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r8_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r2_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (instr[23:22] == 2'b00 || instr[23:22] == 2'b11)
    |=> out_undef && !out_write && out_result == '0);
  a_r1_bad_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (instr[31] || !instr[29] || instr[10]) |=> out_undef && !out_write);
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !instr[30] |=> out_result[127:64] == '0);
  a_r4_reg_low: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && instr[23:22] == 2'b01 |=> !out_isrc_reg[4]);
  a_r7_regnums: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_dst == $past(instr[4:0]) && out_vsrc_reg == $past(instr[9:5]));
endmodule

bind lane_mac_by_elem lane_mac_by_elem_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
  .out_valid(out_valid), .out_write(out_write), .out_undef(out_undef),
  .out_result(out_result), .out_dst(out_dst), .out_vsrc_reg(out_vsrc_reg),
  .out_isrc_reg(out_isrc_reg)
);

// File: tb/lane_mac_by_elem_bench.sv
module lane_mac_by_elem_bench;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [127:0] vsrc = '0, isrc = '0, acc = '0;
  logic out_valid, out_write, out_undef;
  logic [127:0] out_result;
  logic [4:0] out_dst, out_vsrc_reg, out_isrc_reg;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lane_mac_by_elem u_lane_mac_by_elem (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .vsrc(vsrc), .isrc(isrc), .acc(acc), .out_valid(out_valid),
    .out_write(out_write), .out_undef(out_undef), .out_result(out_result),
    .out_dst(out_dst), .out_vsrc_reg(out_vsrc_reg), .out_isrc_reg(out_isrc_reg));

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit q, input logic [1:0] sz, input bit h, input bit l,
                                     input bit m, input logic [3:0] rm, input logic [4:0] rn,
                                     input logic [4:0] rd);
    return {1'b0, q, 1'b1, 5'b01111, sz, l, m, rm, 4'b0000, h, 1'b0, rn, rd};
  endfunction

  function automatic logic [127:0] model(input logic [31:0] w, input logic [127:0] a,
                                         input logic [127:0] b, input logic [127:0] c);
    int es, n, idx;
    logic [63:0] mask, sel, x, y, r;
    logic [127:0] out;
    out = '0;
    es = (w[23:22] == 2'b01) ? 16 : 32;
    n = (w[30] ? 128 : 64) / es;
    idx = (es == 16) ? int'({w[11], w[21], w[20]}) : int'({w[11], w[21]});
    mask = (64'd1 << es) - 64'd1;
    sel = 64'(b >> (idx * es)) & mask;
    for (int e = 0; e < n; e++) begin
      x = 64'(a >> (e * es)) & mask;
      y = 64'(c >> (e * es)) & mask;
      r = (y + x * sel) & mask;
      out = out | (128'(r) << (e * es));
    end
    return out;
  endfunction

  task automatic issue(input logic [31:0] w, input logic [127:0] a, input logic [127:0] b,
                       input logic [127:0] c);
    @(negedge clk);
    instr = w; vsrc = a; isrc = b; acc = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic t_reset();
    chk(!out_valid && !out_write && !out_undef && out_result == '0, "R9 reset",
        {out_valid, out_write, out_undef, out_result[124:0]}, '0);
  endtask

  task automatic t_lanes16();
    logic [31:0] w;
    logic [127:0] a, b, c;
    a = {8{16'hFFFF}}; c = {8{16'h0003}};
    b = 128'h0; b[7*16 +: 16] = 16'h0002;
    w = mk(1, 2'b01, 1, 1, 1, 4'hA, 5'd3, 5'd7);
    issue(w, a, b, c);
    chk(out_result == {8{16'h0001}}, "R6 wrap16", out_result, {8{16'h0001}});
    chk(out_valid && out_write && !out_undef, "R8 write16", {out_valid, out_write, out_undef}, 3'b110);
    chk(out_isrc_reg == 5'h0A, "R4 reg16", out_isrc_reg, 5'h0A);
    w = mk(0, 2'b01, 0, 1, 0, 4'h5, 5'd1, 5'd2);
    b = rnd128(); a = rnd128(); c = rnd128();
    issue(w, a, b, c);
    chk(out_result == model(w, a, b, c), "R4 idx2 half", out_result, model(w, a, b, c));
  endtask

  task automatic t_lanes32();
    logic [31:0] w;
    logic [127:0] a, b, c;
    a = {4{32'h0001_0000}}; c = {4{32'hFFFF_FFFF}};
    b = 128'h0; b[3*32 +: 32] = 32'h0001_0000;
    w = mk(1, 2'b10, 1, 1, 1, 4'h3, 5'd9, 5'd31);
    issue(w, a, b, c);
    chk(out_result == {4{32'hFFFF_FFFF}}, "R6 trunc32", out_result, {4{32'hFFFF_FFFF}});
    chk(out_isrc_reg == 5'h13, "R5 reg32", out_isrc_reg, 5'h13);
    chk(out_dst == 5'd31 && out_vsrc_reg == 5'd9, "R7 regs", {out_dst, out_vsrc_reg}, {5'd31, 5'd9});
    w = mk(0, 2'b10, 0, 1, 0, 4'h0, 5'd0, 5'd0);
    a = rnd128(); b = rnd128(); c = rnd128();
    issue(w, a, b, c);
    chk(out_result == model(w, a, b, c) && out_result[127:64] == '0, "R3 half32",
        out_result, model(w, a, b, c));
  endtask

  task automatic t_random();
    logic [31:0] w;
    logic [127:0] a, b, c, e;
    for (int i = 0; i < 64; i++) begin
      w = mk(1'($urandom), (($urandom & 1) != 0) ? 2'b10 : 2'b01, 1'($urandom), 1'($urandom),
             1'($urandom), 4'($urandom), 5'($urandom), 5'($urandom));
      a = rnd128(); b = rnd128(); c = rnd128();
      issue(w, a, b, c);
      e = model(w, a, b, c);
      chk(out_result == e, "R6 random", out_result, e);
    end
  endtask

  task automatic t_undef();
    logic [31:0] w;
    w = mk(1, 2'b00, 0, 0, 0, 4'h1, 5'd1, 5'd1);
    issue(w, rnd128(), rnd128(), rnd128());
    chk(out_undef && !out_write && out_result == '0, "R2 size00", out_result, '0);
    w = mk(1, 2'b11, 1, 0, 1, 4'h1, 5'd1, 5'd1);
    issue(w, rnd128(), rnd128(), rnd128());
    chk(out_undef && !out_write && out_result == '0, "R2 size11", out_result, '0);
    w = mk(1, 2'b01, 0, 0, 0, 4'h1, 5'd1, 5'd1);
    w[13] = 1'b1;
    issue(w, rnd128(), rnd128(), rnd128());
    chk(out_undef && !out_write && out_result == '0, "R1 opcode", out_result, '0);
    w = mk(1, 2'b10, 0, 0, 0, 4'h1, 5'd1, 5'd1);
    w[29] = 1'b0;
    issue(w, rnd128(), rnd128(), rnd128());
    chk(out_undef && !out_write, "R1 bit29", {out_undef, out_write}, 2'b10);
  endtask

  task automatic t_hold();
    logic [127:0] keep;
    issue(mk(1, 2'b01, 0, 0, 1, 4'h2, 5'd4, 5'd5), rnd128(), rnd128(), rnd128());
    keep = out_result;
    @(negedge clk);
    chk(!out_valid && !out_write, "R8 one-cycle", {out_valid, out_write}, 2'b00);
    chk(out_result == keep, "R8 hold", out_result, keep);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_lanes16();
    t_lanes32();
    t_undef();
    t_hold();
    t_random();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule